// File: doc/BRIEF.md
# SPI Event Interrupt Aggregator

This block gathers single-cycle event pulses from up to four SPI channels, plus a slave wake-up event and an end-of-word-count event, into one sticky status word. Each channel owns a four-bit group of that word. Software reads the word through a small register port. It clears pending bits by writing ones to them. It chooses which pending bits raise the single interrupt line by writing a matching enable word.

A test control sets every implemented status bit while it is held at one. This lets software exercise its interrupt handlers without any real SPI traffic. The register port is a plain register interface: a write strobe with an address and data, and a read data bus that follows the address combinationally. Event inputs are level samples taken on each clock edge. A pulse is one clock wide.

Register map, selected by `reg_addr`: 0 is the status word, 1 is the enable word, 2 is the test control with its set-all flag in bit 0, and 3 always reads zero.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the status word, the enable word, the test control and `irq_o` are all zero.
- R2: A pulse on an event input of channel c sets status bit 4c+0 for transmit-empty, 4c+1 for transmit-underflow and 4c+2 for receive-full, in the clock edge that samples the pulse. The bit then stays set until it is cleared.
- R3: Events of a channel whose `ch_en_i` bit is 0 leave the status word unchanged.
- R4: The receive-overflow event sets status bit 3 only while channel 0 is enabled and `slave_mode_i` is 1.
- R5: The wake-up event sets bit 16, but only while `slave_mode_i` is 1. The end-of-word-count event sets bit 17 whenever it pulses.
- R6: A write to address 0 clears every status bit whose data bit is 1. Bits written with 0 keep their value.
- R7: If an event and a write-one clear reach the same status bit in the same cycle, the bit stays set.
- R8: The enable word at address 1 holds one bit per status bit, at the same position. `irq_o` is the OR of status AND enable, taken through one register, so it changes one clock after the status word changes.
- R9: While bit 0 of the test control at address 2 is 1, every implemented status bit is set on each clock. This holds even when a clear is written in the same cycle.
- R10: Unimplemented positions (7, 11, 15 and 18 to 31, for four channels) read as zero in the status and enable words and ignore writes. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register select |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register |
| ch_en_i | input | NUM_CH | Per-channel enable; events are recorded only when this is 1 |
| slave_mode_i | input | 1 | Slave mode indication |
| tx_empty_i | input | NUM_CH | Transmit-empty event pulses |
| tx_udf_i | input | NUM_CH | Transmit-underflow event pulses |
| rx_full_i | input | NUM_CH | Receive-full event pulses |
| rx_ovf_i | input | 1 | Receive-overflow event pulse (channel 0) |
| wake_i | input | 1 | Slave wake-up event pulse |
| wcnt_end_i | input | 1 | End-of-word-count event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs and the register strobe are sampled only on rising clock edges. They also assume these inputs hold stable values at those edges. The stimulus meets this by changing every input on the falling edge and holding it for a full cycle. The assertions also assume a write is one clock wide. The bench always drops the write strobe on the next falling edge. The clear and stickiness checks are limited to bit 0, and the stimulus exercises that bit together with the other channels' bits.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int STRIDE   = 4;
  localparam int WAKE_BIT = 16;
  localparam int WCNT_BIT = 17;
  localparam int STAT_W   = 18;

  // Mask of implemented status positions for a given channel count
  function automatic logic [STAT_W-1:0] impl_mask(input int nch);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[STRIDE*c + 0] = 1'b1;
      m[STRIDE*c + 1] = 1'b1;
      m[STRIDE*c + 2] = 1'b1;
    end
    m[3]        = 1'b1;
    m[WAKE_BIT] = 1'b1;
    m[WCNT_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/spi_irq_event_map.sv
module spi_irq_event_map
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              slave_mode,
  input  logic [NUM_CH-1:0] tx_empty,
  input  logic [NUM_CH-1:0] tx_udf,
  input  logic [NUM_CH-1:0] rx_full,
  input  logic              rx_ovf,
  input  logic              wake,
  input  logic              wcnt_end,
  output logic [STAT_W-1:0] set_vec
);
  logic [NUM_CH*STRIDE-1:0] ch_bits;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic ovf_here;
      if (c == 0) begin : g_ovf
        assign ovf_here = rx_ovf & slave_mode;
      end else begin : g_no_ovf
        assign ovf_here = 1'b0;
      end
      assign ch_bits[STRIDE*c +: STRIDE] =
        {ovf_here, rx_full[c], tx_udf[c], tx_empty[c]} & {STRIDE{ch_en[c]}};
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    set_vec[NUM_CH*STRIDE-1:0] = ch_bits;
    set_vec[WAKE_BIT] = wake & slave_mode;
    set_vec[WCNT_BIT] = wcnt_end;
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] enable_q,
  output logic              test_q,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_CH);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(2);

  logic [STAT_W-1:0] clr_vec, force_vec, status_d;

  always_comb begin
    clr_vec   = (we && addr == A_STAT) ? wdata[STAT_W-1:0] : '0;
    force_vec = test_q ? MASK : '0;
    status_d  = ((status_q & ~clr_vec) | set_vec | force_vec) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      test_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      if (we && addr == A_EN)   enable_q <= wdata[STAT_W-1:0] & MASK;
      if (we && addr == A_TEST) test_q   <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata[STAT_W-1:0] = status_q;
      A_EN:    rdata[STAT_W-1:0] = enable_q;
      A_TEST:  rdata[0]          = test_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] enable,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & enable);
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic              slave_mode_i,
  input  logic [NUM_CH-1:0] tx_empty_i,
  input  logic [NUM_CH-1:0] tx_udf_i,
  input  logic [NUM_CH-1:0] rx_full_i,
  input  logic              rx_ovf_i,
  input  logic              wake_i,
  input  logic              wcnt_end_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] set_vec, status_q, enable_q;
  logic              test_q;

  spi_irq_event_map #(.NUM_CH(NUM_CH)) u_map (
    .ch_en(ch_en_i), .slave_mode(slave_mode_i),
    .tx_empty(tx_empty_i), .tx_udf(tx_udf_i), .rx_full(rx_full_i),
    .rx_ovf(rx_ovf_i), .wake(wake_i), .wcnt_end(wcnt_end_i),
    .set_vec(set_vec)
  );

  spi_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .set_vec(set_vec), .status_q(status_q),
    .enable_q(enable_q), .test_q(test_q), .rdata(reg_rdata_o)
  );

  spi_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q), .irq(irq_o)
  );
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] enable_q,
  input logic              test_q,
  input logic              irq_o
);
  localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_CH);
  logic clr0;
  assign clr0 = reg_we_i && reg_addr_i == ADDR_W'(0) && reg_wdata_i[0];

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq_o) || $past(|(status_q & enable_q)));

  // R10
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | enable_q) & ~MASK) == '0);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> status_q[0]);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !set_vec[0] && !test_q) |=> !status_q[0]);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !clr0) |=> status_q[0]);

  // R9
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |=> (status_q == MASK));
endmodule

bind spi_irq_status spi_irq_status_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .set_vec(set_vec), .status_q(status_q),
  .enable_q(enable_q), .test_q(test_q), .irq_o(irq_o)
);

// File: tb/spi_irq_status_tb_top.sv
module spi_irq_status_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 2;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] ch_en = '0;
  logic slave = 1'b0;
  logic [NCH-1:0] te = '0, tu = '0, rf = '0;
  logic ovf = 1'b0, wk = 1'b0, wc = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          sel_q[$];
  event        go;

  always #5 clk = ~clk;

  spi_irq_status #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ch_en_i(ch_en),
    .slave_mode_i(slave), .tx_empty_i(te), .tx_udf_i(tu), .rx_full_i(rf),
    .rx_ovf_i(ovf), .wake_i(wk), .wcnt_end_i(wc), .irq_o(irq)
  );

  // Monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(go);
      #1;
      while (exp_q.size() > 0) begin
        logic [31:0] e, a;
        string t;
        int s;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        s = sel_q.pop_front();
        a = (s == 0) ? reg_rdata : {31'b0, irq};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
        end
      end
    end
  end

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); sel_q.push_back(0);
    ->go;
    #2;
  endtask

  task automatic expect_irq(input logic e, input string t);
    exp_q.push_back({31'b0, e}); tag_q.push_back(t); sel_q.push_back(1);
    ->go;
    #2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] p_te, input logic [3:0] p_tu,
                       input logic [3:0] p_rf, input logic p_ovf,
                       input logic p_wk, input logic p_wc);
    te = p_te; tu = p_tu; rf = p_rf; ovf = p_ovf; wk = p_wk; wc = p_wc;
    @(negedge clk);
    te = '0; tu = '0; rf = '0; ovf = 1'b0; wk = 1'b0; wc = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_rd(0, 32'h0, "R1 status");
    expect_rd(1, 32'h0, "R1 enable");
    expect_rd(2, 32'h0, "R1 test");
    expect_irq(1'b0, "R1 irq");

    // R3 disabled channels record nothing
    pulse(4'hF, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
    expect_rd(0, 32'h0, "R3 disabled channels");

    // R2 R4 R5: ch0 and ch2 enabled, master mode
    ch_en = 4'b0101;
    pulse(4'hF, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1);
    expect_rd(0, 32'h0002_0101, "R2 R4 R5 master mode events");
    slave = 1'b1;
    pulse(4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0);
    expect_rd(0, 32'h0003_0109, "R4 R5 slave mode events");
    pulse(4'h0, 4'hF, 4'b0110, 1'b0, 1'b0, 1'b0);
    expect_rd(0, 32'h0003_070B, "R2 underflow and full");
    @(negedge clk);
    expect_rd(0, 32'h0003_070B, "R2 sticky");
    expect_irq(1'b0, "R8 masked");

    // R10 enable masked to implemented bits, R8 irq
    wr(1, 32'hFFFF_FFFF);
    expect_rd(1, 32'h0003_777F, "R10 enable implemented only");
    @(negedge clk);
    expect_irq(1'b1, "R8 irq raised");

    // R6 write-one-to-clear
    wr(0, 32'h0000_0101);
    expect_rd(0, 32'h0003_060A, "R6 clear selected");
    wr(0, 32'h0);
    expect_rd(0, 32'h0003_060A, "R6 zero write no effect");
    wr(0, 32'hFFFC_8880);
    expect_rd(0, 32'h0003_060A, "R10 unimplemented write ignored");
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, "R6 clear all");
    expect_irq(1'b1, "R8 irq one cycle late");
    @(negedge clk);
    expect_irq(1'b0, "R8 irq dropped");

    // R7 event beats clear
    te = 4'b0001;
    wr(0, 32'h0000_0001);
    te = '0;
    expect_rd(0, 32'h0000_0001, "R7 event wins");
    wr(0, 32'h1);
    expect_rd(0, 32'h0, "R7 cleared after");

    // R9 test forces all
    wr(2, 32'h1);
    expect_rd(2, 32'h1, "R9 test readback");
    @(negedge clk);
    expect_rd(0, 32'h0003_777F, "R9 all set");
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0003_777F, "R9 clear overridden");
    wr(2, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, "R9 released");

    // R8 single enable bit
    wr(1, 32'h0002_0000);
    pulse(4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
    expect_rd(0, 32'h0002_0000, "R5 word count end");
    expect_irq(1'b0, "R8 not yet");
    @(negedge clk);
    expect_irq(1'b1, "R8 enabled bit irq");

    // R10 spare address
    expect_rd(3, 32'h0, "R10 address 3");

    done = 1;
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule